// File: doc/BRIEF.md
# Nonvolatile Setting Shadow Controller

This block keeps the 7-bit working code that feeds a 128-step DAC, and it looks after that code's nonvolatile copy. The working register lives in flops and drives the DAC at all times. A small memory port (request, write enable, write data, read data, busy) reaches a nonvolatile cell that holds the saved code. After reset the block reads the saved code into the working register, and it accepts no command until that read is done. A falling edge on the active-low write-protect pin makes it read the saved code again.

A command interface has two kinds of command. A plain write changes only the working register, and the change is seen on the next clock edge. A program command also changes the working register. When write-protect is high, it also starts a nonvolatile write and keeps a busy flag raised for a fixed write time. That time is counted in clock cycles and can be shortened by a divider parameter. When write-protect is low, a program command leaves the memory alone and raises a sticky rejected flag. The DAC step count on the output is the working code plus one.

Top module: `nvs_shadow_ctrl`

## Requirements
- R1: After reset is released, the block issues exactly one read (`mem_req`=1, `mem_we`=0). It then waits until `mem_busy` is low and copies `mem_rdata` into `setting`. `cmd_ready` stays low until that copy has been made. In reset, `setting`=0, `cmd_ready`=0, `prog_busy`=0 and `prog_rejected`=0. The memory is expected to raise `mem_busy` in the cycle after a request it cannot finish at once, and to hold valid read data whenever `mem_busy` is low.
- R2: `dac_steps` always equals `setting`+1. It is therefore 1 when the code is 0 and 128 when the code is 127.
- R3: A command accepted with `cmd_prog`=0 writes `cmd_data` into `setting` on that clock edge and causes no memory access. Such commands are also accepted while a program cycle is running.
- R4: A command accepted with `cmd_prog`=1 while the synchronized write-protect level is high does three things. It writes `cmd_data` into `setting`. It issues one memory write with `mem_we`=1 and `mem_wdata`=`cmd_data`. It holds `prog_busy` high for WRITE_TICKS/TIME_DIV+2 clock cycles, counted from the accepting edge.
- R5: A program command accepted while `prog_busy` is high is ignored: `setting` does not change and no memory write is issued.
- R6: A program command accepted while write-protect is low updates `setting` and issues no memory write. It sets `prog_rejected`, which stays at 1 until reset.
- R7: After two synchronizer stages, a high-to-low transition of `wp_n` makes the block read the memory again and load `setting` from it. `cmd_ready` is low during that read.
- R8: If write-protect falls while a program cycle is running, the reload waits until `prog_busy` falls. It then loads the value that was just programmed.
- R9: A low-to-high transition of `wp_n` causes no read and leaves `setting` unchanged.
- R10: `mem_req` is only raised while `mem_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| cmd_valid | input | 1 | Command present |
| cmd_prog | input | 1 | 1 = program command, 0 = plain register write |
| cmd_data | input | 7 | Code carried by the command |
| cmd_ready | output | 1 | Block is ready to accept a command |
| setting | output | 7 | Working code |
| dac_steps | output | 8 | DAC step count, `setting`+1 |
| prog_busy | output | 1 | Program cycle in progress |
| prog_rejected | output | 1 | Sticky flag: a program command arrived while protected |
| mem_req | output | 1 | Memory access request, one cycle |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_wdata | output | 7 | Data to be programmed |
| mem_rdata | input | 7 | Stored code from memory |
| mem_busy | input | 1 | Memory access in progress |

## Verification
The hardest state to reach is the deferred reload. Write-protect must fall while the program timer is still counting. A plain write must also have moved `setting` away from the programmed value, so that the later reload shows up as a change. The stimulus first starts a program cycle with the pin high. Inside the busy window it issues a plain write with a different code, then drops the pin. It checks that no read occurs before `prog_busy` falls and that exactly one read occurs afterwards. A memory model in the testbench counts reads and writes, which lets the stimulus confirm that ignored and rejected program commands never reach the memory.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_LREQ  = 3'd0,
    ST_LWAIT = 3'd1,
    ST_IDLE  = 3'd2,
    ST_PREQ  = 3'd3,
    ST_PWAIT = 3'd4
  } nvs_state_e;
endpackage

// File: rtl/nvs_wp_sync.sv
module nvs_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic wp_level,
  output logic wp_fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its one-cycle delay
  logic [STAGES:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi <= STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= wp_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign wp_level = chain[STAGES-1];
  assign wp_fall  = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/nvs_prog_timer.sv
module nvs_prog_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | busy;
    cnt_d  = start ? LOAD : cnt_q - {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = |cnt_q;
endmodule

// File: rtl/nvs_step_map.sv
module nvs_step_map #(
  parameter int W = 7
) (
  input  logic [W-1:0] code,
  output logic [W:0]   steps
);
  assign steps = {1'b0, code} + {{W{1'b0}}, 1'b1};
endmodule

// File: rtl/nvs_shadow_ctrl.sv
module nvs_shadow_ctrl #(
  parameter int SET_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int WRITE_TICKS = 25_000_000,
  parameter int TIME_DIV    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             cmd_valid,
  input  logic             cmd_prog,
  input  logic [SET_W-1:0] cmd_data,
  output logic             cmd_ready,
  output logic [SET_W-1:0] setting,
  output logic [SET_W:0]   dac_steps,
  output logic             prog_busy,
  output logic             prog_rejected,
  output logic             mem_req,
  output logic             mem_we,
  output logic [SET_W-1:0] mem_wdata,
  input  logic [SET_W-1:0] mem_rdata,
  input  logic             mem_busy
);
  import nvs_pkg::*;

  localparam int PROG_RAW    = WRITE_TICKS / TIME_DIV;
  localparam int PROG_CYCLES = (PROG_RAW < 1) ? 1 : PROG_RAW;

  nvs_state_e       state_q, state_d;
  logic [SET_W-1:0] set_q, set_d;
  logic [SET_W-1:0] wdat_q;
  logic             rej_q, rej_d;
  logic             pend_q, pend_d;
  logic             wp_level, wp_fall;
  logic             tmr_start, tmr_busy;
  logic             accept, set_en, wdat_en, in_prog, pend_any;

  nvs_wp_sync #(.STAGES(SYNC_STAGES)) u_wp (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .wp_level(wp_level), .wp_fall(wp_fall)
  );

  nvs_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(tmr_busy)
  );

  nvs_step_map #(.W(SET_W)) u_map (
    .code(set_q), .steps(dac_steps)
  );

  assign in_prog   = (state_q == ST_PREQ) || (state_q == ST_PWAIT);
  assign cmd_ready = ((state_q == ST_IDLE) || in_prog) && !pend_q && !wp_fall;
  assign accept    = cmd_valid && cmd_ready;
  assign pend_any  = pend_q || wp_fall;

  // next-state process
  always_comb begin
    state_d   = state_q;
    set_d     = set_q;
    rej_d     = rej_q;
    pend_d    = pend_q;
    tmr_start = 1'b0;
    wdat_en   = 1'b0;
    case (state_q)
      ST_LREQ: begin
        if (!mem_busy) state_d = ST_LWAIT;
      end
      ST_LWAIT: begin
        if (!mem_busy) begin
          set_d   = mem_rdata;
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (accept) begin
          set_d = cmd_data;
          if (cmd_prog) begin
            if (wp_level) begin
              state_d = ST_PREQ;
              wdat_en = 1'b1;
            end else begin
              rej_d = 1'b1;
            end
          end
        end
      end
      ST_PREQ: begin
        pend_d = pend_any;
        if (accept && !cmd_prog) set_d = cmd_data;
        if (!mem_busy) begin
          tmr_start = 1'b1;
          state_d   = ST_PWAIT;
        end
      end
      ST_PWAIT: begin
        pend_d = pend_any;
        if (accept && !cmd_prog) set_d = cmd_data;
        if (!tmr_busy) begin
          state_d = pend_any ? ST_LREQ : ST_IDLE;
          pend_d  = 1'b0;
        end
      end
      default: state_d = ST_LREQ;
    endcase
    if (state_q == ST_IDLE && wp_fall) state_d = ST_LREQ;
  end

  assign set_en = (set_d != set_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LREQ;
      set_q   <= '0;
      wdat_q  <= '0;
      rej_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rej_q   <= rej_d;
      pend_q  <= pend_d;
      if (set_en)  set_q  <= set_d;
      if (wdat_en) wdat_q <= cmd_data;
    end
  end

  assign setting       = set_q;
  assign prog_busy     = in_prog;
  assign prog_rejected = rej_q;
  assign mem_req       = ((state_q == ST_LREQ) || (state_q == ST_PREQ)) && !mem_busy;
  assign mem_we        = (state_q == ST_PREQ);
  assign mem_wdata     = wdat_q;
endmodule

// File: rtl/nvs_shadow_ctrl_chk.sv
module nvs_shadow_ctrl_chk #(
  parameter int SET_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic [SET_W:0]   dac_steps,
  input logic             prog_busy,
  input logic             prog_rejected,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_busy
);
  localparam logic [SET_W:0] MAX_STEPS = {1'b1, {SET_W{1'b0}}};

  AST_STEPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_steps != '0) && (dac_steps <= MAX_STEPS)); // R2

  AST_REQ_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_busy); // R10

  AST_LOAD_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !cmd_ready); // R1

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !(mem_req && mem_we)); // R5

  AST_WRITE_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> prog_busy); // R4

  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_rejected |=> prog_rejected); // R6
endmodule

bind nvs_shadow_ctrl nvs_shadow_ctrl_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .dac_steps(dac_steps),
  .prog_busy(prog_busy), .prog_rejected(prog_rejected), .mem_req(mem_req),
  .mem_we(mem_we), .mem_busy(mem_busy)
);

// File: tb/nvs_shadow_ctrl_tb.sv
module nvs_shadow_ctrl_tb;
  localparam int TICKS = 25_000_000;
  localparam int DIV   = 250_000;
  localparam int L     = TICKS / DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_prog = 1'b0;
  logic [6:0] cmd_data = '0;
  logic       cmd_ready;
  logic [6:0] setting;
  logic [7:0] dac_steps;
  logic       prog_busy, prog_rejected, mem_req, mem_we;
  logic [6:0] mem_wdata, mem_rdata;
  logic       mem_busy;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  nvs_shadow_ctrl #(.WRITE_TICKS(TICKS), .TIME_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_prog(cmd_prog), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .setting(setting), .dac_steps(dac_steps), .prog_busy(prog_busy),
    .prog_rejected(prog_rejected), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  // memory model
  logic [6:0] stored = 7'h2A;
  logic       mb = 1'b0;
  int         mcnt = 0;
  int         n_rd = 0;
  int         n_wr = 0;
  assign mem_busy  = mb;
  assign mem_rdata = stored;

  always @(posedge clk) begin
    if (rst_n && mem_req && !mb) begin
      mb   <= 1'b1;
      mcnt <= mem_we ? 10 : 5;
      if (mem_we) begin
        stored <= mem_wdata;
        n_wr   <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
      end
    end else if (mb) begin
      if (mcnt <= 1) mb <= 1'b0;
      mcnt <= mcnt - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [6:0] exp_q[$];
  logic [6:0] mon_prev = '0;

  task automatic expect_set(input logic [6:0] v);
    exp_q.push_back(v);
  endtask

  always @(negedge clk) begin
    if (rst_n && setting !== mon_prev) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected setting change", int'(setting), int'(mon_prev));
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        chk("R1/R3/R4/R7 setting", int'(setting), int'(e));
        chk("R2 dac_steps", int'(dac_steps), int'(e) + 1);
      end
      mon_prev = setting;
    end
  end

  task automatic send_cmd(input logic prog, input logic [6:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_prog  = prog;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_prog  = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int busy_n;
    int r0;
    int w0;
    wait_cyc(3);
    // R1 reset state
    chk("R1 reset setting", int'(setting), 0);
    chk("R1 reset cmd_ready", int'(cmd_ready), 0);
    chk("R1 reset prog_busy", int'(prog_busy), 0);
    chk("R1 reset prog_rejected", int'(prog_rejected), 0);
    expect_set(7'h2A);
    rst_n = 1'b1;
    while (!cmd_ready) @(negedge clk);
    chk("R1 reads after reset", n_rd, 1);
    chk("R1 loaded value", int'(setting), 'h2A);

    // R3 / R2 boundaries
    expect_set(7'h7F);
    send_cmd(1'b0, 7'h7F);
    chk("R2 steps at max", int'(dac_steps), 128);
    expect_set(7'h00);
    send_cmd(1'b0, 7'h00);
    chk("R2 steps at zero", int'(dac_steps), 1);
    chk("R3 no memory write", n_wr, 0);

    // R4 program with write-protect high
    expect_set(7'h15);
    send_cmd(1'b1, 7'h15);
    busy_n = 0;
    while (prog_busy) begin
      busy_n++;
      @(negedge clk);
    end
    chk("R4 busy length", busy_n, L + 2);
    chk("R4 write count", n_wr, 1);
    chk("R4 stored data", int'(stored), 'h15);
    wait_cyc(12);

    // R5 program ignored while busy, R3 plain write accepted while busy
    expect_set(7'h44);
    send_cmd(1'b1, 7'h44);
    wait_cyc(3);
    send_cmd(1'b1, 7'h33);
    wait_cyc(2);
    chk("R5 setting kept", int'(setting), 'h44);
    chk("R5 no second write", n_wr, 2);
    expect_set(7'h50);
    send_cmd(1'b0, 7'h50);
    chk("R3 write during busy", int'(setting), 'h50);
    while (prog_busy) @(negedge clk);
    chk("R5 stored after ignore", int'(stored), 'h44);
    wait_cyc(12);

    // R7 reload on falling edge
    r0 = n_rd;
    expect_set(7'h44);
    wp_n = 1'b0;
    while (n_rd == r0) @(negedge clk);
    chk("R7 cmd_ready low in reload", int'(cmd_ready), 0);
    while (!cmd_ready) @(negedge clk);
    chk("R7 reload value", int'(setting), 'h44);

    // R6 program while protected
    w0 = n_wr;
    expect_set(7'h11);
    send_cmd(1'b1, 7'h11);
    wait_cyc(2);
    chk("R6 rejected flag", int'(prog_rejected), 1);
    chk("R6 no busy", int'(prog_busy), 0);
    chk("R6 no write", n_wr, w0);

    // R9 rising edge does nothing
    r0 = n_rd;
    wp_n = 1'b1;
    wait_cyc(10);
    chk("R9 no read", n_rd, r0);
    chk("R9 setting kept", int'(setting), 'h11);
    chk("R6 flag sticky", int'(prog_rejected), 1);
    wait_cyc(5);

    // R8 deferred reload
    expect_set(7'h66);
    send_cmd(1'b1, 7'h66);
    wait_cyc(3);
    expect_set(7'h70);
    send_cmd(1'b0, 7'h70);
    r0 = n_rd;
    expect_set(7'h66);
    wp_n = 1'b0;
    wait_cyc(8);
    chk("R8 busy still", int'(prog_busy), 1);
    chk("R8 no read during busy", n_rd, r0);
    while (prog_busy) @(negedge clk);
    wait_cyc(1);
    while (!cmd_ready) @(negedge clk);
    chk("R8 one read after busy", n_rd, r0 + 1);
    chk("R8 reloaded value", int'(setting), 'h66);
    wait_cyc(10);
    chk("scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule